// File: doc/BRIEF.md
# Configurable Interrupt Request Conditioner

This block takes up to four asynchronous external request lines and turns each one into either a prioritised interrupt request or a DMA trigger. Each line is configured by one byte of a single 32-bit control register. The byte chooses the active condition (a low or high level, or a falling or rising edge), a 3-bit code, and a route bit. With the route bit clear, the code is an interrupt priority and zero disables the line. With the route bit set, the code names one of four DMA channels, and codes beyond the channel count are suppressed.

Every request input is first brought into the clock domain by a two-flop synchroniser. A level source asks for service for as long as its input sits at the active value. An edge source sets a sticky pending flag, which the line's acknowledge clears. Among the pending interrupt-routed lines, the block presents the one with the highest priority, with ties going to the lowest line number. It reports that line's index and level on registered outputs. A DMA-routed line produces a one-cycle strobe on its channel for every qualifying edge or level assertion, and it never reaches the interrupt output.

Software is expected to program the active condition before giving a line a non-zero code or a DMA route.

Top module: `irq_cond`

## Requirements
- R1: After reset, the control register reads zero, `irqValid` is 0, `dmaStrobe` is 0, and no line raises an interrupt while its input is low.
- R2: Line n owns register bits [8n+7:8n]. Within its byte, bits [2:0] are the code, bit [3] is the route bit (1 = DMA) and bits [5:4] are the active condition. A write stores these six bits of every byte, and bits [7:6] of every byte read back as 0.
- R3: Active condition 00 is low-level and 01 is high-level. A level-mode interrupt line is reported while its input is at the active value and is dropped once the input leaves it, with no acknowledge needed.
- R4: Active condition 10 is falling-edge and 11 is rising-edge. A qualifying edge sets a pending flag, which stays set after the input returns to its idle value. Pulsing `reqAck[n]` clears it.
- R5: `reqAck[n]` has no effect on a level-mode line whose input is still active.
- R6: With the route bit clear, code 0 disables the line and codes 1 to 7 are its priority, reported on `irqLevel`. When nothing is pending, `irqValid`, `irqLine` and `irqLevel` are all 0.
- R7: The interrupt output names the pending interrupt-routed line with the highest code, and the lowest line index among equal codes.
- R8: With the route bit set and code c in 0..3, every qualifying edge, or every entry of the input into its active level, gives exactly one single-cycle pulse on `dmaStrobe[c]`. Holding the input active or releasing it gives no further pulse.
- R9: With the route bit set and code 4..7, the line produces neither a DMA strobe nor an interrupt.
- R10: A DMA-routed line never appears on the interrupt output, whatever its code.
- R11: A change on a request input reaches the output after a fixed latency. Counting clock edges from the first edge that samples the change, a level-mode interrupt shows after the third edge and not after the second. An edge-mode interrupt shows one edge later than that. A DMA strobe is high for the cycle that follows the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 32 | Control register write data |
| cfgRdata | output | 32 | Control register contents |
| reqIn | input | 4 | Asynchronous request lines |
| reqAck | input | 4 | Per-line acknowledge, clears an edge pending flag |
| irqValid | output | 1 | An interrupt-routed line is pending |
| irqLine | output | 2 | Index of the winning line |
| irqLevel | output | 3 | Priority of the winning line |
| dmaStrobe | output | 4 | One-cycle trigger per DMA channel |

## Verification
The bench builds the block with its default four lines and a two-stage synchroniser. This small configuration allows exhaustive sweeps. All 4096 combinations of the four priority codes are walked to check arbitration and tie-breaking. Every active condition is tried with every code, both on the interrupt route and on the DMA route, on every line. DMA pulses are counted per channel over a window that covers both assertion and release, so that extra or missing strobes show up. The expected values are computed arithmetically from the code and line index.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int LVL_W  = 3;
  localparam int MODE_W = 2;
  localparam int SLOT_W = 8;
  localparam int CHAN_W = 2;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int USED_W = LVL_W + 1 + MODE_W;

  typedef struct packed {
    logic              edgeMode;
    logic              polarity;
    logic              irqRoute;
    logic              dmaRoute;
    logic [CHAN_W-1:0] chan;
    logic [LVL_W-1:0]  level;
  } lineCtrl_t;
endpackage

// File: rtl/irq_cond_ctrl.sv
module irq_cond_ctrl
  import irq_cond_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int REG_W = NUM_LINES * SLOT_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic [REG_W-1:0]                cfgWdata,
  output logic [REG_W-1:0]                cfgRdata,
  output lineCtrl_t [NUM_LINES-1:0]       lineCtrl
);
  function automatic logic [REG_W-1:0] keepMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      m[i*SLOT_W +: SLOT_W] = SLOT_W'((1 << USED_W) - 1);
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] KEEP = keepMask();

  logic [REG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata & KEEP;
  end

  assign cfgRdata = cfgQ;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      logic [LVL_W-1:0]  code;
      logic              route;
      logic [MODE_W-1:0] mode;
      code  = cfgQ[i*SLOT_W +: LVL_W];
      route = cfgQ[i*SLOT_W + LVL_W];
      mode  = cfgQ[i*SLOT_W + LVL_W + 1 +: MODE_W];
      lineCtrl[i].edgeMode = mode[1];
      lineCtrl[i].polarity = mode[0];
      lineCtrl[i].irqRoute = !route && (code != '0);
      lineCtrl[i].dmaRoute = route && (code < LVL_W'(NUM_CHAN));
      lineCtrl[i].chan     = code[CHAN_W-1:0];
      lineCtrl[i].level    = code;
    end
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata == ($past(cfgWdata) & KEEP));
endmodule

// File: rtl/irq_cond_arb.sv
module irq_cond_arb
  import irq_cond_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]            pend,
  input  logic [NUM_LINES-1:0][LVL_W-1:0] lvl,
  output logic                            winValid,
  output logic [LINE_W-1:0]               winLine,
  output logic [LVL_W-1:0]                winLevel
);
  always_comb begin
    winLevel = '0;
    winLine  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i] && (lvl[i] > winLevel)) begin
        winLevel = lvl[i];
        winLine  = LINE_W'(i);
      end
    end
    winValid = (winLevel != '0);
  end
endmodule

// File: rtl/irq_cond_dp.sv
module irq_cond_dp
  import irq_cond_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_LINES-1:0]      reqIn,
  input  logic [NUM_LINES-1:0]      reqAck,
  input  lineCtrl_t [NUM_LINES-1:0] lineCtrl,
  output logic                      irqValid,
  output logic [LINE_W-1:0]         irqLine,
  output logic [LVL_W-1:0]          irqLevel,
  output logic [NUM_CHAN-1:0]       dmaStrobe
);
  logic [NUM_LINES-1:0] syncQ [SYNC_DEPTH];
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] curSync;
  logic [NUM_LINES-1:0] activeNow, activePrev, evt;
  logic [NUM_LINES-1:0] edgeFlag, pend, dmaLine;
  logic [NUM_LINES-1:0][LVL_W-1:0] lvl;
  logic [NUM_CHAN-1:0]  dmaNext;
  logic                 winValid;
  logic [LINE_W-1:0]    winLine;
  logic [LVL_W-1:0]     winLevel;

  // synchroniser chain plus one history stage for event detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= reqIn;
      for (int k = 1; k < SYNC_DEPTH; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[SYNC_DEPTH-1];
    end
  end

  assign curSync = syncQ[SYNC_DEPTH-1];

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      activeNow[i]  = (curSync[i] == lineCtrl[i].polarity);
      activePrev[i] = (prevQ[i] == lineCtrl[i].polarity);
      evt[i]        = activeNow[i] && !activePrev[i];
      pend[i]       = lineCtrl[i].irqRoute &&
                      (lineCtrl[i].edgeMode ? edgeFlag[i] : activeNow[i]);
      dmaLine[i]    = lineCtrl[i].dmaRoute && evt[i];
      lvl[i]        = lineCtrl[i].level;
    end
  end

  // sticky flags for edge-mode interrupt lines; a new event wins over ack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeFlag <= '0;
    else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        edgeFlag[i] <= lineCtrl[i].edgeMode && lineCtrl[i].irqRoute &&
                       (evt[i] || (edgeFlag[i] && !reqAck[i]));
      end
    end
  end

  always_comb begin
    dmaNext = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (dmaLine[i] && (int'(lineCtrl[i].chan) == c)) dmaNext[c] = 1'b1;
      end
    end
  end

  irq_cond_arb #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_arb (
    .pend     (pend),
    .lvl      (lvl),
    .winValid (winValid),
    .winLine  (winLine),
    .winLevel (winLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqLine   <= '0;
      irqLevel  <= '0;
      dmaStrobe <= '0;
    end else begin
      irqValid  <= winValid;
      irqLine   <= winLine;
      irqLevel  <= winLevel;
      dmaStrobe <= dmaNext;
    end
  end

  assert_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> irqLevel != '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    assert_edge_source_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(edgeFlag[g]) |-> $past(evt[g]));
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
      (reqAck[g] && !evt[g]) |=> !edgeFlag[g]);
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
      dmaLine[g] |=> (!dmaLine[g] || !$stable(lineCtrl[g])));
  end
endmodule

// File: rtl/irq_cond.sv
module irq_cond
  import irq_cond_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int REG_W = NUM_LINES * SLOT_W,
  parameter int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [REG_W-1:0]     cfgWdata,
  output logic [REG_W-1:0]     cfgRdata,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] reqAck,
  output logic                 irqValid,
  output logic [LINE_W-1:0]    irqLine,
  output logic [LVL_W-1:0]     irqLevel,
  output logic [NUM_CHAN-1:0]  dmaStrobe
);
  lineCtrl_t [NUM_LINES-1:0] lineCtrl;

  irq_cond_ctrl #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .lineCtrl (lineCtrl)
  );

  irq_cond_dp #(.NUM_LINES(NUM_LINES), .SYNC_DEPTH(SYNC_DEPTH), .LINE_W(LINE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .reqAck    (reqAck),
    .lineCtrl  (lineCtrl),
    .irqValid  (irqValid),
    .irqLine   (irqLine),
    .irqLevel  (irqLevel),
    .dmaStrobe (dmaStrobe)
  );
endmodule

// File: tb/irq_cond_tb.sv
module irq_cond_tb;
  localparam int NL = 4;
  localparam int RW = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN;
  logic          cfgWe;
  logic [RW-1:0] cfgWdata;
  logic [RW-1:0] cfgRdata;
  logic [NL-1:0] reqIn;
  logic [NL-1:0] reqAck;
  logic          irqValid;
  logic [1:0]    irqLine;
  logic [2:0]    irqLevel;
  logic [NC-1:0] dmaStrobe;

  irq_cond u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqIn(reqIn), .reqAck(reqAck), .irqValid(irqValid), .irqLine(irqLine),
    .irqLevel(irqLevel), .dmaStrobe(dmaStrobe)
  );

  int checks = 0;
  int errors = 0;
  int strobeTot [NC];
  int irqTot = 0;

  initial for (int c = 0; c < NC; c++) strobeTot[c] = 0;

  always @(negedge clk) begin
    for (int c = 0; c < NC; c++) if (dmaStrobe[c] === 1'b1) strobeTot[c]++;
    if (irqValid === 1'b1) irqTot++;
  end

  task automatic checkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(logic [RW-1:0] v);
    cfgWe = 1'b1;
    cfgWdata = v;
    tick(1);
    cfgWe = 1'b0;
  endtask

  task automatic pulseAck(int line);
    reqAck[line] = 1'b1;
    tick(1);
    reqAck[line] = 1'b0;
  endtask

  function automatic logic [RW-1:0] slotAt(int line, logic [1:0] mode, logic route, logic [2:0] code);
    logic [RW-1:0] v;
    v = '0;
    v[line*8 +: 8] = {2'b00, mode, route, code};
    return v;
  endfunction

  function automatic logic [5:0] irqExp(logic valid, int line, int lvl);
    return valid ? {1'b1, 2'(line), 3'(lvl)} : 6'd0;
  endfunction

  function automatic logic [5:0] irqAct();
    return {irqValid, irqLine, irqLevel};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int snap [NC];
    int irqSnap;
    rstN = 1'b0; cfgWe = 1'b0; cfgWdata = '0; reqIn = '0; reqAck = '0;
    tick(3);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    checkEq("R1", "cfgRdata", cfgRdata, 0);
    checkEq("R1", "irq", irqAct(), 0);
    checkEq("R1", "dmaStrobe", dmaStrobe, 0);
    checkEq("R1", "irq seen since reset", irqTot, 0);

    // R2 storage and reserved bits
    writeCfg(32'hFFFF_FFFF);
    checkEq("R2", "all ones readback", cfgRdata, 32'h3F3F_3F3F);
    writeCfg(32'hA55A_C33C);
    checkEq("R2", "pattern readback", cfgRdata, 32'h251A_033C);
    writeCfg('0);
    checkEq("R2", "cleared readback", cfgRdata, 0);
    tick(3);

    // R11 latency, level mode
    writeCfg(slotAt(0, 2'b01, 1'b0, 3'd5));
    tick(4);
    reqIn[0] = 1'b1;
    tick(2);
    checkEq("R11", "level not yet after two edges", irqAct(), 0);
    tick(1);
    checkEq("R11", "level shows after third edge", irqAct(), irqExp(1, 0, 5));
    reqIn[0] = 1'b0;
    tick(4);

    // R11 latency, edge mode and DMA strobe
    writeCfg(slotAt(0, 2'b11, 1'b0, 3'd4));
    tick(4);
    reqIn[0] = 1'b1;
    tick(3);
    checkEq("R11", "edge not yet after third edge", irqAct(), 0);
    tick(1);
    checkEq("R11", "edge shows after fourth edge", irqAct(), irqExp(1, 0, 4));
    pulseAck(0);
    reqIn[0] = 1'b0;
    writeCfg(slotAt(0, 2'b11, 1'b1, 3'd2));
    tick(4);
    reqIn[0] = 1'b1;
    tick(3);
    checkEq("R11", "dma strobe after third edge", dmaStrobe, 4'b0100);
    tick(1);
    checkEq("R11", "dma strobe gone after fourth edge", dmaStrobe, 0);
    reqIn[0] = 1'b0;
    writeCfg('0);
    tick(4);

    // R3 R5 R6 level modes on every line and code
    for (int line = 0; line < NL; line++) begin
      for (int m = 0; m < 2; m++) begin
        for (int lv = 0; lv < 8; lv++) begin
          logic pol;
          pol = 1'(m);
          reqIn[line] = ~pol;
          writeCfg('0);
          tick(3);
          writeCfg(slotAt(line, 2'(m), 1'b0, 3'(lv)));
          tick(3);
          checkEq("R3", "level inactive", irqAct(), 0);
          reqIn[line] = pol;
          tick(4);
          checkEq(lv == 0 ? "R6" : "R3", "level active", irqAct(), irqExp(lv != 0, line, lv));
          pulseAck(line);
          tick(2);
          checkEq("R5", "ack on active level", irqAct(), irqExp(lv != 0, line, lv));
          reqIn[line] = ~pol;
          tick(4);
          checkEq("R3", "level released", irqAct(), 0);
        end
      end
      reqIn[line] = 1'b0;
    end
    writeCfg('0);
    tick(4);

    // R4 edge modes: sticky until ack
    for (int line = 0; line < NL; line++) begin
      for (int m = 2; m < 4; m++) begin
        for (int lv = 1; lv < 8; lv++) begin
          logic pol;
          pol = 1'(m & 1);
          reqIn[line] = ~pol;
          writeCfg('0);
          tick(3);
          writeCfg(slotAt(line, 2'(m), 1'b0, 3'(lv)));
          tick(4);
          checkEq("R4", "edge idle", irqAct(), 0);
          reqIn[line] = pol;
          tick(5);
          checkEq("R4", "edge pending", irqAct(), irqExp(1, line, lv));
          reqIn[line] = ~pol;
          tick(5);
          checkEq("R4", "edge sticky after release", irqAct(), irqExp(1, line, lv));
          pulseAck(line);
          tick(3);
          checkEq("R4", "edge cleared by ack", irqAct(), 0);
        end
      end
      reqIn[line] = 1'b0;
    end
    writeCfg('0);
    tick(4);

    // R8 R9 R10 DMA routing, every line, condition and code
    for (int line = 0; line < NL; line++) begin
      for (int m = 0; m < 4; m++) begin
        for (int code = 0; code < 8; code++) begin
          logic pol;
          pol = 1'(m & 1);
          reqIn[line] = ~pol;
          writeCfg('0);
          tick(3);
          writeCfg(slotAt(line, 2'(m), 1'b1, 3'(code)));
          tick(4);
          for (int c = 0; c < NC; c++) snap[c] = strobeTot[c];
          irqSnap = irqTot;
          reqIn[line] = pol;
          tick(7);
          reqIn[line] = ~pol;
          tick(7);
          for (int c = 0; c < NC; c++) begin
            checkEq(code < 4 ? "R8" : "R9", "dma pulses on channel",
                    strobeTot[c] - snap[c], (code < 4 && c == code) ? 1 : 0);
          end
          checkEq("R10", "dma line on irq output", irqTot - irqSnap, 0);
        end
      end
      reqIn[line] = 1'b0;
    end
    writeCfg('0);
    tick(4);

    // R9 R10 mixed: invalid DMA code 7 must not outrank a real level-2 source
    reqIn = 4'hF;
    writeCfg(slotAt(0, 2'b01, 1'b0, 3'd2) | slotAt(3, 2'b01, 1'b1, 3'd7));
    tick(4);
    checkEq("R10", "dma line excluded from arbitration", irqAct(), irqExp(1, 0, 2));

    // R7 exhaustive arbitration over all code combinations
    for (int combo = 0; combo < 4096; combo++) begin
      logic [RW-1:0] v;
      int best;
      int bestIdx;
      v = '0;
      best = 0;
      bestIdx = 0;
      for (int i = 0; i < NL; i++) begin
        int lv;
        lv = (combo >> (3 * i)) & 7;
        v = v | slotAt(i, 2'b01, 1'b0, 3'(lv));
        if (lv > best) begin
          best = lv;
          bestIdx = i;
        end
      end
      writeCfg(v);
      tick(2);
      checkEq("R7", "arbitration winner", irqAct(), irqExp(best != 0, bestIdx, best));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule